// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This block watches an 8-bit temperature code delivered by an on-die sensor and turns threshold crossings into interrupts and a hardware trip. Software programs three rising levels and three falling levels over a simple 32-bit word-addressed register bus. Each level has a pending status bit that is set when the code crosses the level. The pending bits are masked by an enable word and combined into a single level-sensitive IRQ. Pending bits are cleared by writing ones to a clear register.

The highest rising level also serves as the hardware-trip level. When the trip function is armed, a code at or above that level asserts a latched trip output. A power controller uses this output to cut power. The trip output releases only when the core enable is removed. A control field selects which remote sensor feeds the code, and that field is brought out as a port.

Sensor samples arrive with a one-cycle valid strobe. Crossings are judged sample against sample, so a level is reported once per crossing and not on every sample taken while the code stays past it.

Top module: `thermal_alarm_unit`

## Requirements
- R1: After reset every register reads 0 at every address, `irq` is 0, `trip` is 0 and `sensor_sel` is 0.
- R2: Register map by word address.
  - 0 is control: bit 0 is core enable, bit 12 is trip enable, and bits [23:20] are the sensor select, which drives `sensor_sel`. All other control bits read 0.
  - 1 is the rising-level word and 2 is the falling-level word. Both are full 32-bit read/write.
  - 3 is interrupt enable, of which only bits 0, 4, 8, 16, 20 and 24 are stored.
  - 4 is pending status. It is read-only, and writes to it are ignored.
  - 5 is clear. It is write-only and reads 0.
  - 6 holds the last sampled code in bits [7:0].
- R3: Rising level k (k = 0, 1, 2) has its threshold in bits [8k+15:8k+8] of the rising word and its pending bit at position 4k. On the clock edge of a valid sample taken with the core enabled, that bit sets if the code is at or above the threshold and the previous sample of that level was below it. A level counts as below when the core has just been enabled.
- R4: Falling level k has its threshold in bits [8k+15:8k+8] of the falling word and its pending bit at position 16+4k. The bit sets on a valid sample, with the core enabled, whose code is below the threshold when the previous sample was at or above it. A level counts as below when the core has just been enabled, so the first sample after enabling never reports a fall.
- R5: While the core enable is 0, samples set no pending bit.
- R6: Writing the clear register clears exactly the pending bits written as 1. Bits written as 0 keep their value.
- R7: If a crossing and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R8: `irq` is 1 exactly when some pending bit and its enable bit are both 1. A bit stays pending while it is masked.
- R9: With core enable and trip enable both set, `trip` rises on the clock edge after the stored code (address 6) is at or above bits [31:24] of the rising word. Without trip enable it stays 0.
- R10: Once asserted, `trip` stays 1 even when trip enable is cleared or the code drops. It falls on the clock edge after the one that stores core enable as 0.
- R11: Bits [31:24] of the rising word are at once the rising level 2 threshold and the trip level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| temp_valid | input | 1 | One-cycle strobe marking a new sensor sample |
| temp_code | input | 8 | Sensor temperature code |
| sensor_sel | output | 4 | Sensor select field from the control register |
| irq | output | 1 | Masked OR of pending bits |
| trip | output | 1 | Latched hardware thermal trip |

## Verification
A sensor sample that crosses a level and a software write to the clear register can land on the same clock edge. One can set a pending bit while the other removes it. The bench provokes this by first leaving one falling bit pending. In a single cycle it then drives a sample that crosses rising level 0 together with a clear write covering both that rising bit and the pending falling bit. The status must then read back only the freshly crossed rising bit: the new event survives, and the other cleared bit is gone.

// File: rtl/thal_pkg.sv
package thal_pkg;

   localparam int DW          = 32;
   localparam int SLOT_W      = 8;
   localparam int CORE_BIT    = 0;
   localparam int TRIP_BIT    = 12;
   localparam int SEL_LSB     = 20;
   localparam int EVT_STRIDE  = 4;
   localparam int FALL_BASE   = 16;
   localparam int MAX_LEVELS  = 3;

   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_RISE  = 3'd1,
      RA_FALL  = 3'd2,
      RA_IEN   = 3'd3,
      RA_STAT  = 3'd4,
      RA_CLR   = 3'd5,
      RA_TEMP  = 3'd6
   } reg_addr_e;

   function automatic int rise_pos(input int lvl);
      return EVT_STRIDE * lvl;
   endfunction

   function automatic int fall_pos(input int lvl);
      return FALL_BASE + EVT_STRIDE * lvl;
   endfunction

   function automatic logic [DW-1:0] evt_mask(input int levels);
      logic [DW-1:0] m;
      m = '0;
      for (int i = 0; i < levels; i++) begin
         m[rise_pos(i)] = 1'b1;
         m[fall_pos(i)] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/thal_level_det.sv
module thal_level_det #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              sample,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] rise_thr,
   input  logic [CODE_W-1:0] fall_thr,
   output logic              rise_evt,
   output logic              fall_evt
);

   logic above_rise_q;
   logic above_fall_q;
   logic at_rise;
   logic at_fall;

   assign at_rise  = (code >= rise_thr);
   assign at_fall  = (code >= fall_thr);
   assign rise_evt = enable & sample & at_rise & ~above_rise_q;
   assign fall_evt = enable & sample & ~at_fall & above_fall_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         above_rise_q <= 1'b0;
         above_fall_q <= 1'b0;
      end else if (!enable) begin
         above_rise_q <= 1'b0;
         above_fall_q <= 1'b0;
      end else if (sample) begin
         above_rise_q <= at_rise;
         above_fall_q <= at_fall;
      end
   end

endmodule

// File: rtl/thal_trip.sv
module thal_trip #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_en,
   input  logic              trip_en,
   input  logic [CODE_W-1:0] code_q,
   input  logic [CODE_W-1:0] trip_lvl,
   output logic              trip
);

   logic trip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trip_q <= 1'b0;
      else if (!core_en)
         trip_q <= 1'b0;
      else if (trip_en && (code_q >= trip_lvl))
         trip_q <= 1'b1;
   end

   assign trip = trip_q;

endmodule

// File: rtl/thal_regs.sv
module thal_regs
   import thal_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CODE_W = 8,
   parameter int SEL_W  = 4,
   parameter int LEVELS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              temp_valid,
   input  logic [CODE_W-1:0] temp_code,
   input  logic [DW-1:0]     evt_vec,
   output logic              core_en,
   output logic              trip_en,
   output logic [SEL_W-1:0]  sel,
   output logic [CODE_W-1:0] rise_thr [LEVELS],
   output logic [CODE_W-1:0] fall_thr [LEVELS],
   output logic [CODE_W-1:0] trip_lvl,
   output logic [DW-1:0]     ien,
   output logic [DW-1:0]     stat,
   output logic [CODE_W-1:0] temp_q
);

   localparam logic [DW-1:0] VALID = evt_mask(LEVELS);

   logic [DW-1:0] rise_q, fall_q, ien_q, stat_q, clr_mask, ctrl_word;
   logic          core_q, trip_en_q;
   logic [SEL_W-1:0] sel_q;
   logic [CODE_W-1:0] code_q;
   logic wr_ctrl, wr_rise, wr_fall, wr_ien, wr_clr;

   assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(RA_CTRL));
   assign wr_rise = bus_we && (bus_addr == ADDR_W'(RA_RISE));
   assign wr_fall = bus_we && (bus_addr == ADDR_W'(RA_FALL));
   assign wr_ien  = bus_we && (bus_addr == ADDR_W'(RA_IEN));
   assign wr_clr  = bus_we && (bus_addr == ADDR_W'(RA_CLR));

   assign clr_mask = wr_clr ? (bus_wdata & VALID) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_q    <= 1'b0;
         trip_en_q <= 1'b0;
         sel_q     <= '0;
         rise_q    <= '0;
         fall_q    <= '0;
         ien_q     <= '0;
         stat_q    <= '0;
         code_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            core_q    <= bus_wdata[CORE_BIT];
            trip_en_q <= bus_wdata[TRIP_BIT];
            sel_q     <= bus_wdata[SEL_LSB +: SEL_W];
         end
         if (wr_rise) rise_q <= bus_wdata;
         if (wr_fall) fall_q <= bus_wdata;
         if (wr_ien)  ien_q  <= bus_wdata & VALID;
         stat_q <= (stat_q & ~clr_mask) | (evt_vec & VALID);
         if (temp_valid) code_q <= temp_code;
      end
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CORE_BIT] = core_q;
      ctrl_word[TRIP_BIT] = trip_en_q;
      ctrl_word[SEL_LSB +: SEL_W] = sel_q;
   end

   always_comb begin
      case (bus_addr)
         ADDR_W'(RA_CTRL): bus_rdata = ctrl_word;
         ADDR_W'(RA_RISE): bus_rdata = rise_q;
         ADDR_W'(RA_FALL): bus_rdata = fall_q;
         ADDR_W'(RA_IEN):  bus_rdata = ien_q;
         ADDR_W'(RA_STAT): bus_rdata = stat_q;
         ADDR_W'(RA_TEMP): bus_rdata = {{(DW-CODE_W){1'b0}}, code_q};
         default:          bus_rdata = '0;
      endcase
   end

   for (genvar k = 0; k < LEVELS; k++) begin : g_thr
      assign rise_thr[k] = rise_q[SLOT_W*(k+1) +: CODE_W];
      assign fall_thr[k] = fall_q[SLOT_W*(k+1) +: CODE_W];
   end

   assign trip_lvl = rise_q[SLOT_W*MAX_LEVELS +: CODE_W];
   assign core_en  = core_q;
   assign trip_en  = trip_en_q;
   assign sel      = sel_q;
   assign ien      = ien_q;
   assign stat     = stat_q;
   assign temp_q   = code_q;

endmodule

// File: rtl/thermal_alarm_unit.sv
module thermal_alarm_unit
   import thal_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int CODE_W = 8,
   parameter int SEL_W  = 4,
   parameter int LEVELS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              temp_valid,
   input  logic [CODE_W-1:0] temp_code,
   output logic [SEL_W-1:0]  sensor_sel,
   output logic              irq,
   output logic              trip
);

   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must cover seven registers");
   end
   if (CODE_W < 1 || CODE_W > SLOT_W) begin : g_bad_code
      $error("CODE_W must fit one threshold byte");
   end
   if (LEVELS < 1 || LEVELS > MAX_LEVELS) begin : g_bad_lvl
      $error("LEVELS must be 1 to 3");
   end
   if (SEL_W < 1 || SEL_LSB + SEL_W > DW) begin : g_bad_sel
      $error("SEL_W does not fit the control word");
   end

   logic              core_en, trip_en;
   logic [CODE_W-1:0] rise_thr [LEVELS];
   logic [CODE_W-1:0] fall_thr [LEVELS];
   logic [CODE_W-1:0] trip_lvl, temp_q;
   logic [DW-1:0]     ien_vec, stat_vec, evt_vec;
   logic [LEVELS-1:0] rise_e, fall_e;

   thal_regs #(
      .ADDR_W(ADDR_W), .CODE_W(CODE_W), .SEL_W(SEL_W), .LEVELS(LEVELS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .temp_valid(temp_valid), .temp_code(temp_code),
      .evt_vec(evt_vec),
      .core_en(core_en), .trip_en(trip_en), .sel(sensor_sel),
      .rise_thr(rise_thr), .fall_thr(fall_thr), .trip_lvl(trip_lvl),
      .ien(ien_vec), .stat(stat_vec), .temp_q(temp_q)
   );

   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      thal_level_det #(.CODE_W(CODE_W)) u_det (
         .clk(clk), .rst_n(rst_n),
         .enable(core_en), .sample(temp_valid), .code(temp_code),
         .rise_thr(rise_thr[k]), .fall_thr(fall_thr[k]),
         .rise_evt(rise_e[k]), .fall_evt(fall_e[k])
      );
   end

   always_comb begin
      evt_vec = '0;
      for (int k = 0; k < LEVELS; k++) begin
         evt_vec[rise_pos(k)] = rise_e[k];
         evt_vec[fall_pos(k)] = fall_e[k];
      end
   end

   assign irq = |(stat_vec & ien_vec);

   thal_trip #(.CODE_W(CODE_W)) u_trip (
      .clk(clk), .rst_n(rst_n),
      .core_en(core_en), .trip_en(trip_en),
      .code_q(temp_q), .trip_lvl(trip_lvl),
      .trip(trip)
   );

endmodule

// File: rtl/thal_checker.sv
module thal_checker
   import thal_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic              temp_valid,
   input logic              core_en,
   input logic [DW-1:0]     stat,
   input logic [DW-1:0]     ien,
   input logic              irq,
   input logic              trip
);

   logic clr_wr;
   assign clr_wr = bus_we && (bus_addr == ADDR_W'(RA_CLR));

   // R6: a full clear with no sample empties the status
   p_clear_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (bus_wdata == '1) && !temp_valid) |=> (stat == '0));

   // R5: with the core off and no clear, status holds
   p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_en && !clr_wr) |=> (stat == $past(stat)));

   // R3: new pending bits only follow a sample
   p_need_sample_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !temp_valid |=> ((stat & ~$past(stat)) == '0));

   // R8: nothing enabled means no interrupt
   p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

   // R10: core off releases the trip
   p_trip_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> !trip);

   // R10: trip holds while the core stays on
   p_trip_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (trip && core_en) |=> trip);

endmodule

bind thermal_alarm_unit thal_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .temp_valid(temp_valid), .core_en(core_en),
   .stat(stat_vec), .ien(ien_vec), .irq(irq), .trip(trip)
);

// File: tb/sim_thermal_alarm_unit.sv
`timescale 1ns/1ps
module sim_thermal_alarm_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        temp_valid = 1'b0;
   logic [7:0]  temp_code = '0;
   logic [3:0]  sensor_sel;
   logic        irq;
   logic        trip;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [2:0] A_CTRL = 3'd0, A_RISE = 3'd1, A_FALL = 3'd2,
                          A_IEN = 3'd3, A_STAT = 3'd4, A_CLR = 3'd5,
                          A_TEMP = 3'd6;

   always #10 clk = ~clk;

   thermal_alarm_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .temp_valid(temp_valid), .temp_code(temp_code),
      .sensor_sel(sensor_sel), .irq(irq), .trip(trip)
   );

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic smp(input logic [7:0] c);
      @(negedge clk);
      temp_valid = 1'b1; temp_code = c;
      @(negedge clk);
      temp_valid = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), d);
         check("R1 reset read", d, 32'h0);
      end
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 trip", {31'b0, trip}, 32'h0);
      check("R1 sensor_sel", {28'b0, sensor_sel}, 32'h0);
   endtask

   task automatic t_regmap();
      logic [31:0] d;
      wr(A_CTRL, 32'hFFFF_FFFF);
      rd(A_CTRL, d);
      check("R2 ctrl fields", d, 32'h00F0_1001);
      check("R2 sensor_sel", {28'b0, sensor_sel}, 32'hF);
      wr(A_CTRL, 32'h0);
      wr(A_IEN, 32'hFFFF_FFFF);
      rd(A_IEN, d);
      check("R2 ien bits", d, 32'h0111_0111);
      wr(A_IEN, 32'h0);
      wr(A_RISE, 32'hA5C3_1E77);
      rd(A_RISE, d);
      check("R2 rise word", d, 32'hA5C3_1E77);
      wr(A_FALL, 32'h1234_5678);
      rd(A_FALL, d);
      check("R2 fall word", d, 32'h1234_5678);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d);
      check("R2 status read-only", d, 32'h0);
      rd(A_CLR, d);
      check("R2 clear reads zero", d, 32'h0);
   endtask

   task automatic t_rise();
      logic [31:0] d;
      wr(A_RISE, 32'h9060_4000);
      wr(A_FALL, 32'h8050_3000);
      wr(A_CTRL, 32'h1);
      smp(8'h20);
      rd(A_STAT, d); check("R3 below all", d, 32'h0);
      smp(8'h45);
      rd(A_STAT, d); check("R3 level0 cross", d, 32'h1);
      rd(A_TEMP, d); check("R2 temp code", d, 32'h45);
      wr(A_CLR, 32'h1);
      smp(8'h45);
      rd(A_STAT, d); check("R3 no repeat while above", d, 32'h0);
      smp(8'h95);
      rd(A_STAT, d); check("R3 levels 1 and 2 cross", d, 32'h110);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(A_CLR, 32'hFFFF_FFFF);
      smp(8'h10);
      rd(A_STAT, d); check("R4 all levels fall", d, 32'h0111_0000);
      wr(A_CLR, 32'h0010_0000);
      rd(A_STAT, d); check("R6 partial clear", d, 32'h0101_0000);
      wr(A_CLR, 32'h0);
      rd(A_STAT, d); check("R6 zero clear no effect", d, 32'h0101_0000);
      wr(A_CLR, 32'hFFFF_FFFF);
      rd(A_STAT, d); check("R6 full clear", d, 32'h0);
   endtask

   task automatic t_off();
      logic [31:0] d;
      wr(A_CTRL, 32'h0);
      smp(8'hA0);
      rd(A_STAT, d); check("R5 core off no event", d, 32'h0);
      wr(A_CTRL, 32'h1);
      smp(8'hA0);
      rd(A_STAT, d); check("R3 after enable counts from below", d, 32'h111);
      wr(A_CLR, 32'hFFFF_FFFF);
      wr(A_CTRL, 32'h0);
      wr(A_CTRL, 32'h1);
      smp(8'h10);
      rd(A_STAT, d); check("R4 no fall on first sample", d, 32'h0);
   endtask

   task automatic t_irq();
      smp(8'h45);
      tick();
      check("R8 masked pending no irq", {31'b0, irq}, 32'h0);
      wr(A_IEN, 32'h1);
      check("R8 enabled pending irq", {31'b0, irq}, 32'h1);
      wr(A_IEN, 32'h10);
      check("R8 other enable no irq", {31'b0, irq}, 32'h0);
      wr(A_IEN, 32'h1);
      wr(A_CLR, 32'h1);
      check("R8 cleared no irq", {31'b0, irq}, 32'h0);
      wr(A_IEN, 32'h0);
   endtask

   task automatic t_collide();
      logic [31:0] d;
      smp(8'h10);
      rd(A_STAT, d); check("R4 level0 fall", d, 32'h0001_0000);
      @(negedge clk);
      temp_valid = 1'b1; temp_code = 8'h45;
      bus_we = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h0001_0001;
      @(negedge clk);
      temp_valid = 1'b0; bus_we = 1'b0;
      rd(A_STAT, d); check("R7 set wins over clear", d, 32'h1);
      wr(A_CLR, 32'hFFFF_FFFF);
   endtask

   task automatic t_trip();
      logic [31:0] d;
      wr(A_CTRL, 32'h1001);
      tick(); tick();
      check("R9 below level no trip", {31'b0, trip}, 32'h0);
      smp(8'h8F);
      tick();
      check("R9 one under level", {31'b0, trip}, 32'h0);
      smp(8'h90);
      check("R9 not before next edge", {31'b0, trip}, 32'h0);
      rd(A_STAT, d); check("R11 level2 shares trip byte", d & 32'h100, 32'h100);
      check("R9 trip asserted", {31'b0, trip}, 32'h1);
      wr(A_CTRL, 32'h1);
      tick();
      check("R10 trip enable off holds", {31'b0, trip}, 32'h1);
      smp(8'h10);
      tick();
      check("R10 cool code holds", {31'b0, trip}, 32'h1);
      wr(A_CTRL, 32'h0);
      tick();
      check("R10 core off releases", {31'b0, trip}, 32'h0);
      wr(A_CTRL, 32'h1);
      smp(8'hA0);
      tick(); tick();
      check("R9 no trip without enable", {31'b0, trip}, 32'h0);
      wr(A_CTRL, 32'h1001);
      tick();
      check("R9 arm with hot code", {31'b0, trip}, 32'h1);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regmap();
      t_rise();
      t_fall();
      t_off();
      t_irq();
      t_collide();
      t_trip();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule